// File: doc/BRIEF.md
# Power-State Sequencer with Configuration Strap Capture

This block owns the chip-level power state and the configuration read at power-up. While power-on reset is held, a small group of shared pads is treated as inputs. On the first clock edge after reset is released, their levels are stored as configuration straps. The pads are then handed over to the clock output drivers for good.

An active-low power-down request can arrive asynchronously. It is passed through a two-flop synchronizer before it can have any effect. Once it takes effect, every output clock group is told to stop. The block then waits for the output stage to confirm that all outputs, including the slow reference and fixed-rate ones, are held low. Only then does it turn off the VCO and the crystal oscillator.

When the request is withdrawn, both oscillators are turned back on. A programmable settling interval runs, and the block also waits for the oscillator-ready handshake. After both conditions are met, the outputs restart. Two per-group clock-stop requests gate their groups in normal operation. They have no effect anywhere else in the sequence.

Top module: `pwrdn_strap_seq`

## Requirements
- R1: While rst_ni is low: strap_oe_o is 0, clk_run_o, cpu_run_o and pci_run_o are 0, vco_en_o and xtal_en_o are 1, and strap_o is 0.
- R2: On the first rising edge after rst_ni goes high, strap_o takes the value of strap_pad_i, strap_oe_o becomes 1 and clk_run_o becomes 1.
- R3: After that capture, strap_o never changes again until the next reset, whatever strap_pad_i does and across any number of power-down cycles; strap_oe_o stays 1.
- R4: pwrdn_ni passes through two synchronizer flops. A low level present before rising edge k makes clk_run_o go to 0 after edge k+2, provided the block was running.
- R5: After clk_run_o goes to 0, vco_en_o and xtal_en_o stay at 1 until out_held_i is sampled as 1. At that edge both go to 0 together, and never before.
- R6: While off, the enables stay at 0 as long as the synchronized request is active. A high level on pwrdn_ni before edge k sets both enables to 1 after edge k+2.
- R7: Once the enables are back on, clk_run_o returns to 1 only after at least WAKE_CYCLES cycles. It also waits until osc_ready_i has been sampled as 1 at the end of that interval. Waiting for a late ready signal does not shorten this minimum.
- R8: cpu_run_o equals clk_run_o ANDed with cpu_stop_ni after a two-flop synchronizer, and pci_run_o does the same with pci_stop_ni. Both stop inputs have no effect while clk_run_o is 0.
- R9: If the request is withdrawn before out_held_i arrives, the stop still completes: the oscillators are turned off and then woken again, and the outputs are not restarted early.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Internal reference clock of the sequencer |
| rst_ni | input | 1 | Power-on reset, asynchronous, active low |
| pwrdn_ni | input | 1 | Asynchronous power-down request, active low |
| cpu_stop_ni | input | 1 | Asynchronous stop request for the processor clock group, active low |
| pci_stop_ni | input | 1 | Asynchronous stop request for the bus clock group, active low |
| strap_pad_i | input | N_STRAP | Pad levels read as configuration straps |
| out_held_i | input | 1 | Output stage confirms every output is held low |
| osc_ready_i | input | 1 | Oscillator and PLL report stable operation |
| strap_oe_o | output | 1 | 1 turns the shared pads into clock outputs |
| strap_o | output | N_STRAP | Captured strap configuration |
| clk_run_o | output | 1 | Enables all output clock groups |
| cpu_run_o | output | 1 | Enables the processor clock group |
| pci_run_o | output | 1 | Enables the stoppable bus clock group |
| vco_en_o | output | 1 | VCO enable |
| xtal_en_o | output | 1 | Crystal oscillator enable |

## Verification
The assertions are checked on every cycle. They cover the shutdown order (oscillators go off only after outputs have stopped and the hold was confirmed), that no output group runs while an oscillator is off, that the pads never go back to input mode, that the captured straps never change, and the minimum settling time between oscillator restart and output restart. What only the bench scenarios can show are the exact synchronizer latencies, that the strap capture takes the pad value at the end of reset and not a later one, that stop requests are ignored during power-down, and that a request withdrawn mid-stop still completes the full off-and-wake cycle.

// File: rtl/pds_pkg.sv
package pds_pkg;
  typedef enum logic [2:0] {
    RESET_SAMPLE = 3'd0,
    RUN          = 3'd1,
    STOPPING     = 3'd2,
    OSC_OFF      = 3'd3,
    WAKEUP       = 3'd4
  } pds_state_e;
endpackage

// File: rtl/pds_sync.sv
module pds_sync #(
  parameter int unsigned          WIDTH   = 1,
  parameter int unsigned          STAGES  = 2,
  parameter logic [WIDTH-1:0]     RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[g] <= RST_VAL;
      else if (g == 0) stg_q[g] <= d_i;
      else stg_q[g] <= stg_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pds_strap.sv
module pds_strap #(
  parameter int unsigned N_STRAP = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               capture_i,
  input  logic [N_STRAP-1:0] pad_i,
  output logic [N_STRAP-1:0] strap_o
);
  logic [N_STRAP-1:0] strap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strap_q <= '0;
    else if (capture_i) strap_q <= pad_i;
  end

  assign strap_o = strap_q;
endmodule

// File: rtl/pds_fsm.sv
module pds_fsm
  import pds_pkg::*;
#(
  parameter int unsigned WAKE_CYCLES = 500000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pd_req_i,
  input  logic       held_i,
  input  logic       ready_i,
  output pds_state_e state_o,
  output logic       capture_o
);
  localparam int unsigned CNT_W = $clog2(WAKE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAKE_CYCLES - 1);

  pds_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= RESET_SAMPLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      RESET_SAMPLE: st_d = RUN;
      RUN:          if (pd_req_i) st_d = STOPPING;
      // finish the stop even if the request is already gone
      STOPPING:     if (held_i) st_d = OSC_OFF;
      OSC_OFF: begin
        if (!pd_req_i) begin
          st_d  = WAKEUP;
          cnt_d = '0;
        end
      end
      WAKEUP: begin
        if (cnt_q == CNT_LAST) begin
          if (ready_i) st_d = RUN;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = RESET_SAMPLE;
    endcase
  end

  assign state_o   = st_q;
  assign capture_o = (st_q == RESET_SAMPLE);
endmodule

// File: rtl/pwrdn_strap_seq.sv
module pwrdn_strap_seq
  import pds_pkg::*;
#(
  parameter int unsigned N_STRAP     = 5,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned WAKE_CYCLES = 500000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pwrdn_ni,
  input  logic               cpu_stop_ni,
  input  logic               pci_stop_ni,
  input  logic [N_STRAP-1:0] strap_pad_i,
  input  logic               out_held_i,
  input  logic               osc_ready_i,
  output logic               strap_oe_o,
  output logic [N_STRAP-1:0] strap_o,
  output logic               clk_run_o,
  output logic               cpu_run_o,
  output logic               pci_run_o,
  output logic               vco_en_o,
  output logic               xtal_en_o
);
  localparam int unsigned N_ASYNC = 3;

  logic [N_ASYNC-1:0] async_sync;
  pds_state_e         state;
  logic               capture;
  logic               running;
  logic               osc_off;

  pds_sync #(
    .WIDTH  (N_ASYNC),
    .STAGES (SYNC_STAGES),
    .RST_VAL({N_ASYNC{1'b1}})
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({pci_stop_ni, cpu_stop_ni, pwrdn_ni}),
    .q_o   (async_sync)
  );

  pds_fsm #(
    .WAKE_CYCLES(WAKE_CYCLES)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pd_req_i (~async_sync[0]),
    .held_i   (out_held_i),
    .ready_i  (osc_ready_i),
    .state_o  (state),
    .capture_o(capture)
  );

  pds_strap #(
    .N_STRAP(N_STRAP)
  ) u_strap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .capture_i(capture),
    .pad_i    (strap_pad_i),
    .strap_o  (strap_o)
  );

  assign running    = (state == RUN);
  assign osc_off    = (state == OSC_OFF);
  assign strap_oe_o = ~capture;
  assign clk_run_o  = running;
  assign cpu_run_o  = running & async_sync[1];
  assign pci_run_o  = running & async_sync[2];
  assign vco_en_o   = ~osc_off;
  assign xtal_en_o  = ~osc_off;
endmodule

// File: rtl/pds_chk.sv
module pds_chk #(
  parameter int unsigned N_STRAP     = 5,
  parameter int unsigned WAKE_CYCLES = 500000
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               out_held_i,
  input logic               strap_oe_o,
  input logic [N_STRAP-1:0] strap_o,
  input logic               clk_run_o,
  input logic               cpu_run_o,
  input logic               pci_run_o,
  input logic               vco_en_o,
  input logic               xtal_en_o
);
  localparam int unsigned CW = $clog2(WAKE_CYCLES + 2);

  logic [CW-1:0] wcnt_q;
  logic          woke_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q <= '0;
      woke_q <= 1'b0;
    end else begin
      if (!vco_en_o) begin
        wcnt_q <= '0;
        woke_q <= 1'b1;
      end else if (!clk_run_o && wcnt_q < CW'(WAKE_CYCLES)) begin
        wcnt_q <= wcnt_q + 1'b1;
      end
    end
  end

  AST_OSC_OFF_AFTER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vco_en_o) |-> $past(out_held_i) && !$past(clk_run_o)); // R5
  AST_OSC_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vco_en_o == xtal_en_o); // R5
  AST_NO_RUN_OSC_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_run_o |-> vco_en_o && xtal_en_o); // R6
  AST_GROUP_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_run_o || pci_run_o) |-> clk_run_o); // R8
  AST_PADS_STAY_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(strap_oe_o) |-> strap_oe_o); // R3
  AST_STRAP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strap_oe_o && $past(strap_oe_o) |-> $stable(strap_o)); // R3
  AST_WAKE_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_run_o) && woke_q |-> wcnt_q >= CW'(WAKE_CYCLES)); // R7
endmodule

bind pwrdn_strap_seq pds_chk #(
  .N_STRAP    (N_STRAP),
  .WAKE_CYCLES(WAKE_CYCLES)
) u_pds_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .out_held_i(out_held_i),
  .strap_oe_o(strap_oe_o),
  .strap_o   (strap_o),
  .clk_run_o (clk_run_o),
  .cpu_run_o (cpu_run_o),
  .pci_run_o (pci_run_o),
  .vco_en_o  (vco_en_o),
  .xtal_en_o (xtal_en_o)
);

// File: tb/pwrdn_strap_seq_tb_top.sv
module pwrdn_strap_seq_tb_top;
  localparam int NS = 5;
  localparam int W  = 12;

  logic clk = 1'b0;
  logic rst_n, pwrdn_n, cpu_stop_n, pci_stop_n, held, ready;
  logic [NS-1:0] pad;
  logic strap_oe, clk_run, cpu_run, pci_run, vco_en, xtal_en;
  logic [NS-1:0] strap;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [2:0] hold_sr = '0;
  int rdy_cnt = 0;
  int rdy_lat = 3;

  always #2 clk = ~clk;

  pwrdn_strap_seq #(.N_STRAP(NS), .WAKE_CYCLES(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pwrdn_ni(pwrdn_n), .cpu_stop_ni(cpu_stop_n),
    .pci_stop_ni(pci_stop_n), .strap_pad_i(pad), .out_held_i(held),
    .osc_ready_i(ready), .strap_oe_o(strap_oe), .strap_o(strap),
    .clk_run_o(clk_run), .cpu_run_o(cpu_run), .pci_run_o(pci_run),
    .vco_en_o(vco_en), .xtal_en_o(xtal_en)
  );

  // output stage and oscillator environment
  always @(posedge clk) begin
    #1;
    hold_sr <= {hold_sr[1:0], ~clk_run};
    held    <= hold_sr[2] & ~clk_run;
    rdy_cnt <= vco_en ? rdy_cnt + 1 : 0;
    ready   <= vco_en && (rdy_cnt >= rdy_lat);
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 sample, 1 run, 2 stopping, 3 off, 4 wake
  int m_st = 0, m_cnt = 0, m_strap = 0;
  bit m_pd1 = 1, m_pd2 = 1, m_c1 = 1, m_c2 = 1, m_p1 = 1, m_p2 = 1;

  always @(negedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_strap = 0;
      m_pd1 = 1; m_pd2 = 1; m_c1 = 1; m_c2 = 1; m_p1 = 1; m_p2 = 1;
    end
    if (!done) begin
      chk(m_st == 0 ? "R1" : "R3", "strap_oe", int'(strap_oe), int'(m_st != 0));
      chk(m_st == 0 ? "R1" : "R3", "strap", int'(strap), m_strap);
      chk("R4", "clk_run", int'(clk_run), int'(m_st == 1));
      chk("R8", "cpu_run", int'(cpu_run), int'(m_st == 1 && m_c2));
      chk("R8", "pci_run", int'(pci_run), int'(m_st == 1 && m_p2));
      chk("R5", "vco_en", int'(vco_en), int'(m_st != 3));
      chk("R5", "xtal_en", int'(xtal_en), int'(m_st != 3));
    end
    if (rst_n) begin
      case (m_st)
        0: begin m_strap = int'(pad); m_st = 1; end
        1: if (!m_pd2) m_st = 2;
        2: if (held) m_st = 3;
        3: if (m_pd2) begin m_st = 4; m_cnt = 0; end
        4: if (m_cnt == W-1) begin if (ready) m_st = 1; end else m_cnt++;
        default: m_st = 0;
      endcase
      m_pd2 = m_pd1; m_pd1 = pwrdn_n;
      m_c2 = m_c1;   m_c1 = cpu_stop_n;
      m_p2 = m_p1;   m_p1 = pci_stop_n;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic power_cycle(input int lat_min, input string req);
    int lat = 0;
    pwrdn_n = 1'b0;
    for (int i = 0; i < 300 && vco_en; i++) cyc(1);
    chk("R5", "oscillators off", int'(vco_en), 0);
    cpu_stop_n = 1'b0; pci_stop_n = 1'b0;   // ignored while down
    cyc(4);
    chk("R6", "still off", int'(vco_en | xtal_en), 0);
    chk("R8", "cpu group idle", int'(cpu_run), 0);
    cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
    pad = ~pad;
    cyc(2);
    pwrdn_n = 1'b1;
    for (int i = 0; i < 300 && !clk_run; i++) begin cyc(1); lat++; end
    chk(req, "wake latency not below minimum", int'(lat >= lat_min), 1);
    chk("R3", "strap kept", int'(strap), 5'b10110);
  endtask

  initial begin
    rst_n = 1'b0; pwrdn_n = 1'b1; cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
    held = 1'b0; ready = 1'b0; pad = 5'b10110;
    cyc(3);
    chk("R1", "reset oe", int'(strap_oe), 0);
    chk("R1", "reset enables", int'(vco_en & xtal_en), 1);
    rst_n = 1'b1;
    cyc(1);
    pad = 5'b01001;
    cyc(1);
    chk("R2", "captured strap", int'(strap), 5'b10110);
    chk("R2", "running", int'(clk_run & strap_oe), 1);
    cyc(3);
    cpu_stop_n = 1'b0; cyc(6); cpu_stop_n = 1'b1;
    pci_stop_n = 1'b0; cyc(6); pci_stop_n = 1'b1;
    cyc(4);
    rdy_lat = 3;  power_cycle(W + 2, "R7");
    cyc(5);
    rdy_lat = 30; power_cycle(32, "R7");
    cyc(5);
    // short request withdrawn before the hold confirmation
    pwrdn_n = 1'b0; cyc(4); pwrdn_n = 1'b1;
    chk("R9", "stop in progress", int'(clk_run), 0);
    begin
      bit seen_off = 0;
      for (int i = 0; i < 300 && !clk_run; i++) begin
        if (!vco_en) seen_off = 1;
        cyc(1);
      end
      chk("R9", "oscillators cycled", int'(seen_off), 1);
      chk("R9", "restarted", int'(clk_run), 1);
    end
    cyc(5);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule